// File: doc/BRIEF.md
# Configurable Market Vector Engine

This engine turns a horizon price vector into the market vector used by an asset-allocation stage. Two mode pins choose among three investor objectives. The first, absolute wealth, passes the horizon prices through unchanged. The second, relative wealth, multiplies the horizon prices by a precomputed square matrix. The third, net profits, subtracts the current prices from the horizon prices, one element at a time. All three objectives use one datapath: a single multiply-accumulate unit and a saturating subtractor.

A one-cycle `start` pulse launches one vector of `NS` elements, and the result comes out as a stream on `out_data`. Every value is a signed Q16.16 number. The input vectors and the matrix are flat buses, and they must stay stable while `busy` is high. The controller is a three-state machine:
- `ST_IDLE` waits for a start.
- `ST_PASS` emits one element per cycle for the absolute and net-profit objectives.
- `ST_MAC` accumulates one matrix row over `NS` cycles and then emits that row's result.

The transitions are:
- `ST_IDLE`→`ST_PASS` on a legal start with `sel_rel=0`.
- `ST_IDLE`→`ST_MAC` on a start with `sel_rel=1`.
- `ST_IDLE`→`ST_IDLE` on an illegal start, which raises `err` instead.
- `ST_PASS`→`ST_IDLE` and `ST_MAC`→`ST_IDLE` once the last element has been emitted.

Top module: `mvu_market_vector`

## Requirements
- R1: After reset, `busy`, `out_valid`, `out_last` and `err` are all low.
- R2: Mode `{sel_net,sel_rel}=00` (absolute) streams `out_data=P[i]` for i = 0..NS-1. Element i is valid exactly i+1 cycles after the clock edge that samples `start`, with no gaps. Element i of a vector occupies bits `[32*i +: 32]`.
- R3: Mode `10` (net profits) streams `P[i]-p[i]` with the same timing as R2. Here `p` is taken from `price_now`.
- R4: Mode `01` (relative) streams `sum over j of K[i][j]*P[j]`, where K[i][j] occupies bits `[32*(i*NS+j) +: 32]`. Each product is shifted arithmetically right by 16 and added to the running sum. Element i is valid exactly (i+1)*NS cycles after the start edge.
- R5: The subtraction in mode `10` saturates to the range [-2^31, 2^31-1].
- R6: Every accumulation step in mode `01` saturates to the range [-2^31, 2^31-1].
- R7: A start with mode `11` raises `err` for exactly the next cycle, produces no `out_valid`, and leaves `busy` low.
- R8: The mode pins are sampled only at an accepted start. Changing them, or pulsing `start`, while `busy` is high has no effect on the values or the timing of the vector in flight.
- R9: `out_last` is high only with element NS-1. `busy` is already low in that cycle, so a new start can be accepted there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one vector when idle |
| sel_rel | input | 1 | Mode bit: matrix-product path |
| sel_net | input | 1 | Mode bit: subtract current prices |
| price_h | input | NS*32 | Horizon price vector P |
| price_now | input | NS*32 | Current price vector p |
| kmat | input | NS*NS*32 | Row-major matrix K |
| busy | output | 1 | A vector is in flight |
| out_valid | output | 1 | `out_data` carries an element |
| out_data | output | 32 | Market vector element, Q16.16 |
| out_last | output | 1 | Final element of the vector |
| err | output | 1 | Illegal mode was requested |

## Verification
The bench builds the engine with its defaults, NS=4 and 32-bit Q16.16 words. A 4x4 matrix lets each output row mix signs and fractions across four accumulation steps. It also gives a clear gap of four cycles between elements in relative mode and one cycle in the other modes. Operands near full scale push both the subtractor and the accumulator into each saturation rail. A mode change during a run, and a restart in the same cycle as the last element, exercise the sampling rule and the hand-off between vectors.

// File: rtl/mv_pkg.sv
package mv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_MAC  = 2'd2
    } mv_state_t;
endpackage

// File: rtl/mv_ctrl.sv
module mv_ctrl #(
    parameter int NS = 4,
    localparam int IW = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          sel_rel,
    input  logic          sel_net,
    output logic          busy,
    output logic          err,
    output logic          emit,
    output logic          mac_en,
    output logic          net_q,
    output logic          last_row,
    output logic [IW-1:0] row,
    output logic [IW-1:0] col
);
    import mv_pkg::*;

    localparam logic [IW-1:0] LASTI = IW'(NS - 1);

    mv_state_t state;
    logic      err_q;

    // State register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            row   <= '0;
            col   <= '0;
            net_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (sel_rel && sel_net) begin
                            err_q <= 1'b1;
                        end else begin
                            row   <= '0;
                            col   <= '0;
                            net_q <= sel_net;
                            state <= sel_rel ? ST_MAC : ST_PASS;
                        end
                    end
                end
                ST_PASS: begin
                    row <= row + IW'(1);
                    if (row == LASTI) state <= ST_IDLE;
                end
                ST_MAC: begin
                    if (col == LASTI) begin
                        col <= '0;
                        row <= row + IW'(1);
                        if (row == LASTI) state <= ST_IDLE;
                    end else begin
                        col <= col + IW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        busy     = 1'b0;
        emit     = 1'b0;
        mac_en   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PASS: begin
                busy = 1'b1;
                emit = 1'b1;
            end
            ST_MAC: begin
                busy   = 1'b1;
                mac_en = 1'b1;
                emit   = (col == LASTI);
            end
            default: ;
        endcase
        last_row = (row == LASTI);
        err      = err_q;
    end
endmodule

// File: rtl/mv_datapath.sv
module mv_datapath #(
    parameter int NS   = 4,
    parameter int W    = 32,
    parameter int FRAC = 16,
    localparam int IW  = (NS > 1) ? $clog2(NS) : 1,
    localparam int DW  = 2 * W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NS*W-1:0]   price_h,
    input  logic [NS*W-1:0]   price_now,
    input  logic [NS*NS*W-1:0] kmat,
    input  logic [IW-1:0]     row,
    input  logic [IW-1:0]     col,
    input  logic              mac_en,
    input  logic              emit,
    input  logic              net_q,
    input  logic              last_row,
    output logic              out_valid,
    output logic [W-1:0]      out_data,
    output logic              out_last
);
    localparam logic signed [DW-1:0] HI = {{(W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [DW-1:0] LO = {{(W+1){1'b1}}, {(W-1){1'b0}}};

    function automatic logic [W-1:0] clip(input logic signed [DW-1:0] v);
        if (v > HI)      return HI[W-1:0];
        else if (v < LO) return LO[W-1:0];
        else             return v[W-1:0];
    endfunction

    logic signed [W-1:0]  acc;
    logic signed [W-1:0]  k_el, pc_el, pr_el, pn_el;
    logic signed [DW-1:0] prod, prod_sh, sum_w, diff_w;
    logic [W-1:0]         sum_sat, diff_sat;

    always_comb begin
        k_el     = kmat[(int'(row) * NS + int'(col)) * W +: W];
        pc_el    = price_h[int'(col) * W +: W];
        pr_el    = price_h[int'(row) * W +: W];
        pn_el    = net_q ? price_now[int'(row) * W +: W] : '0;
        prod     = DW'(k_el) * DW'(pc_el);
        prod_sh  = prod >>> FRAC;
        sum_w    = DW'(acc) + prod_sh;
        sum_sat  = clip(sum_w);
        diff_w   = DW'(pr_el) - DW'(pn_el);
        diff_sat = clip(diff_w);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= emit;
            out_last  <= emit && last_row;
            if (emit) out_data <= mac_en ? sum_sat : diff_sat;
            if (mac_en) acc <= emit ? '0 : sum_sat;
        end
    end
endmodule

// File: rtl/mvu_market_vector.sv
module mvu_market_vector #(
    parameter int NS   = 4,
    parameter int W    = 32,
    parameter int FRAC = 16,
    localparam int IW  = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               sel_rel,
    input  logic               sel_net,
    input  logic [NS*W-1:0]    price_h,
    input  logic [NS*W-1:0]    price_now,
    input  logic [NS*NS*W-1:0] kmat,
    output logic               busy,
    output logic               out_valid,
    output logic [W-1:0]       out_data,
    output logic               out_last,
    output logic               err
);
    logic          emit, mac_en, net_q, last_row;
    logic [IW-1:0] row, col;

    mv_ctrl #(.NS(NS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .sel_rel(sel_rel), .sel_net(sel_net),
        .busy(busy), .err(err), .emit(emit), .mac_en(mac_en),
        .net_q(net_q), .last_row(last_row), .row(row), .col(col)
    );

    mv_datapath #(.NS(NS), .W(W), .FRAC(FRAC)) u_dp (
        .clk(clk), .rst_n(rst_n),
        .price_h(price_h), .price_now(price_now), .kmat(kmat),
        .row(row), .col(col), .mac_en(mac_en), .emit(emit),
        .net_q(net_q), .last_row(last_row),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );
endmodule

// File: rtl/mv_checker.sv
module mv_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sel_rel,
    input logic sel_net,
    input logic busy,
    input logic out_valid,
    input logic out_last,
    input logic err
);
    // R2/R3/R4: an accepted legal start makes the engine busy
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !(sel_rel && sel_net)) |=> busy);

    // R7: illegal mode raises err next cycle and stays idle
    a_r7_illegal_err: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && sel_rel && sel_net) |=> (err && !busy));

    // R7: err never coincides with output data
    a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !out_valid);

    // R9: last flag only with a valid element, and busy already low
    a_r9_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && !busy));

    // R8: output data only follows a busy cycle
    a_r8_valid_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(busy));
endmodule

bind mvu_market_vector mv_checker u_mv_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_rel(sel_rel),
    .sel_net(sel_net), .busy(busy), .out_valid(out_valid),
    .out_last(out_last), .err(err)
);

// File: tb/mvu_market_vector_test.sv
`timescale 1ns/1ps
module mvu_market_vector_test;
    localparam int NS = 4;
    localparam int W  = 32;

    logic               clk = 0;
    logic               rst_n = 0;
    logic               start = 0, sel_rel = 0, sel_net = 0;
    logic [NS*W-1:0]    price_h = '0, price_now = '0;
    logic [NS*NS*W-1:0] kmat = '0;
    logic               busy, out_valid, out_last, err;
    logic [W-1:0]       out_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mvu_market_vector uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sel_rel(sel_rel),
        .sel_net(sel_net), .price_h(price_h), .price_now(price_now),
        .kmat(kmat), .busy(busy), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .err(err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint clip(input longint v);
        if (v > 64'sd2147483647)  return 64'sd2147483647;
        if (v < -64'sd2147483648) return -64'sd2147483648;
        return v;
    endfunction

    function automatic longint getp(input int i);
        return longint'($signed(price_h[i*W +: W]));
    endfunction

    function automatic longint expect_el(input bit rel, input bit net, input int i);
        longint acc;
        if (rel) begin
            acc = 0;
            for (int j = 0; j < NS; j++) begin
                longint kk, pr;
                kk  = longint'($signed(kmat[(i*NS+j)*W +: W]));
                pr  = getp(j);
                acc = clip(acc + ((kk * pr) >>> 16));
            end
            return acc;
        end
        if (net) return clip(getp(i) - longint'($signed(price_now[i*W +: W])));
        return getp(i);
    endfunction

    // Runs one vector; optional disturbance while busy (R8)
    task automatic run_vec(input bit rel, input bit net, input bit disturb, input string req);
        longint got [NS];
        int     at  [NS];
        bit     lst [NS];
        bit     bz  [NS];
        int     n = 0;
        int     gap = rel ? NS : 1;
        @(negedge clk);
        start = 1; sel_rel = rel; sel_net = net;
        @(negedge clk);
        start = 0;
        for (int c = 1; c <= NS*NS + 4; c++) begin
            @(negedge clk);
            if (disturb && c == 1) begin
                sel_rel = !rel; sel_net = 0; start = 1;
            end else begin
                start = 0;
            end
            if (out_valid) begin
                if (n < NS) begin
                    got[n] = longint'($signed(out_data));
                    at[n] = c; lst[n] = out_last; bz[n] = busy;
                end
                n++;
            end
        end
        start = 0; sel_rel = 0; sel_net = 0;
        chk(n == NS, {req, " element count"}, n, NS);
        for (int i = 0; i < NS && i < n; i++) begin
            chk(got[i] == expect_el(rel, net, i), {req, " value"}, got[i], expect_el(rel, net, i));
            chk(at[i] == (i+1)*gap, {req, " timing"}, at[i], (i+1)*gap);
            chk(lst[i] == (i == NS-1), "R9 last flag", lst[i], (i == NS-1));
        end
        if (n >= NS) chk(bz[NS-1] == 0, "R9 busy low at last", bz[NS-1], 0);
    endtask

    task automatic test_reset;
        chk(busy == 0, "R1 busy", busy, 0);
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk(out_last == 0, "R1 out_last", out_last, 0);
        chk(err == 0, "R1 err", err, 0);
    endtask

    task automatic load_prices;
        price_h[0*W +: W] = 32'h0001_8000;   // 1.5
        price_h[1*W +: W] = 32'hFFFE_0000;   // -2.0
        price_h[2*W +: W] = 32'h0003_4000;   // 3.25
        price_h[3*W +: W] = 32'h0000_0001;
        price_now[0*W +: W] = 32'h0000_8000;
        price_now[1*W +: W] = 32'h0001_0000;
        price_now[2*W +: W] = 32'hFFFF_0000;
        price_now[3*W +: W] = 32'h0000_0003;
        for (int i = 0; i < NS; i++)
            for (int j = 0; j < NS; j++)
                kmat[(i*NS+j)*W +: W] = 32'((i == j) ? 32'h0001_0000 :
                    ((i + j) % 2 == 1 ? 32'hFFFF_C000 : 32'h0000_8000)) + 32'(i*7);
    endtask

    task automatic test_abs;       // R2
        load_prices();
        run_vec(0, 0, 0, "R2 absolute");
    endtask

    task automatic test_net;       // R3
        load_prices();
        run_vec(0, 1, 0, "R3 net");
    endtask

    task automatic test_rel;       // R4
        load_prices();
        run_vec(1, 0, 0, "R4 relative");
    endtask

    task automatic test_net_sat;   // R5
        price_h[0*W +: W] = 32'h7FFF_0000; price_now[0*W +: W] = 32'h8000_0000;
        price_h[1*W +: W] = 32'h8000_0000; price_now[1*W +: W] = 32'h0001_0000;
        price_h[2*W +: W] = 32'h7FFF_FFFF; price_now[2*W +: W] = 32'h0000_0000;
        price_h[3*W +: W] = 32'h8000_0001; price_now[3*W +: W] = 32'h0000_0001;
        run_vec(0, 1, 0, "R5 net saturation");
    endtask

    task automatic test_rel_sat;   // R6
        for (int j = 0; j < NS; j++) price_h[j*W +: W] = 32'h7000_0000;
        for (int i = 0; i < NS; i++)
            for (int j = 0; j < NS; j++)
                kmat[(i*NS+j)*W +: W] = (i == 0) ? 32'h7000_0000 :
                                        (i == 1) ? 32'h9000_0000 :
                                        (j == 0) ? 32'h7000_0000 : 32'h9000_0000;
        run_vec(1, 0, 0, "R6 accumulate saturation");
    endtask

    task automatic test_illegal;   // R7
        int v = 0;
        @(negedge clk);
        start = 1; sel_rel = 1; sel_net = 1;
        @(negedge clk);
        start = 0; sel_rel = 0; sel_net = 0;
        chk(err == 1, "R7 err pulse", err, 1);
        chk(busy == 0, "R7 busy stays low", busy, 0);
        @(negedge clk);
        chk(err == 0, "R7 err single cycle", err, 0);
        for (int c = 0; c < 2*NS; c++) begin
            if (out_valid) v++;
            @(negedge clk);
        end
        chk(v == 0, "R7 no output", v, 0);
    endtask

    task automatic test_mode_hold; // R8
        load_prices();
        run_vec(0, 0, 1, "R8 mode held");
    endtask

    task automatic test_back_to_back; // R9
        int t = -1;
        load_prices();
        @(negedge clk);
        start = 1; sel_rel = 0; sel_net = 0;
        @(negedge clk);
        start = 0;
        for (int c = 1; c <= NS + 2 && t < 0; c++) begin
            @(negedge clk);
            if (out_last) begin
                start = 1; sel_net = 1; t = c;
            end
        end
        @(negedge clk);
        start = 0; sel_net = 0;
        chk(busy == 1, "R9 restart on last element", busy, 1);
        @(negedge clk);
        chk(out_valid == 1, "R9 restart output", out_valid, 1);
        chk(longint'($signed(out_data)) == expect_el(0, 1, 0), "R9 restart value",
            longint'($signed(out_data)), expect_el(0, 1, 0));
        repeat (NS + 2) @(negedge clk);
    endtask

    task automatic finish_up;
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1;
        @(negedge clk);
        test_abs();
        test_net();
        test_rel();
        test_net_sat();
        test_rel_sat();
        test_illegal();
        test_mode_hold();
        test_back_to_back();
        finish_up();
    end
endmodule